// File: doc/BRIEF.md
# System Control Register File with Reset Fan-out

This block is a bank of global control registers on a simple 32-bit register bus. It covers system control, clock control, power management, peripheral clock division, two peripheral clock-gate banks, memory configuration, memory clear, system status, an auxiliary reset word, event enables, a revision word, system interrupt enables and four ECC registers. Each register comes out of reset with a fixed value. Two registers shape the data written to them. The system control register keeps only two writable bits and reads its checksum-done flags as always set. The clock control register always reads its clock-ready flag as set.

One offset is a command register and stores nothing. A write to it becomes a one-cycle reset pulse on a 32-bit output vector, one line per peripheral, in the cycle after the write. Three command bits expand into other actions:
- The soft group command selects a fixed set of peripherals that includes both GPIO banks.
- The peripheral group command selects a fixed set that includes the watchdog and leaves out GPIO.
- The system command raises a whole-system reset request. This request stays high until the block itself is reset.

The window is 0x400 bytes. Register k sits at byte offset 4*k, for k from 0 to 17:

| k | Register | k | Register |
|---|---|---|---|
| 0 | sysCtl | 9 | rstAux |
| 1 | rstCmd | 10 | clkGateB |
| 2 | clkCtl | 11 | evtEn |
| 3 | pwrCtl | 12 | revId |
| 4 | pclkDiv | 13 | sysIntEn |
| 5 | clkGateA | 14 | eccErr |
| 6 | memCfg | 15 | eccDet |
| 7 | memClr | 16 | eccIntEn |
| 8 | sysStat | 17 | eccAddr |

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the registers hold these values: sysCtl 0x00021002, clkCtl 0x3E140008, pwrCtl 0x0003F000, memCfg 0x00000005, revId 0x000000A1, clkGateA and clkGateB 0xFFFFFFFF. Every other register holds 0. The outputs rstPulse and sysRstReq are 0.
- R2: A write to any register other than sysCtl, clkCtl and rstCmd stores the full 32-bit word. A read of that register returns the stored word combinationally in the same cycle.
- R3: Only word-aligned accesses (reqAddr[1:0]==0) to offsets 0x00..0x44 are decoded. A read of any other address returns 0. A write to any other address changes no register and raises no pulse.
- R4: A write to sysCtl stores (data & 0x00030000) | 0x00001002.
- R5: A write to clkCtl stores the data with bit 3 (clock ready) forced to 1.
- R6: In rstCmd the individual bits are DMA 0, WDT0 1, GPIO0 2, GPIO1 3, TMR0..TMR3 5..8, UART0 11, UART1 12, SPI1 13, I2C0 16, RTC 17, CNN 25, ADC 26, UART2 28, TRNG 29 and AES 30. Without a group bit, a write drives rstPulse to (data & 0x760339EF) for exactly the one cycle after the write. The other bits are ignored.
- R7: rstCmd bit 31 (peripheral group) without bit 4 replaces the request with the set 0x360339E3: all UARTs, ADC, CNN, TRNG, RTC, I2C0, SPI1, TMR0..3, WDT0 and DMA. Any individual bits in the same write are discarded. Bits 4, 9 and 31 never appear on rstPulse.
- R8: rstCmd bit 4 (soft group) replaces the request with 0x360339ED. This is the peripheral set with GPIO0 and GPIO1 added and WDT0 removed. It wins when bit 31 is also set.
- R9: rstCmd bit 9 sets sysRstReq from the next cycle on. The request stays high through later accesses until rstN is asserted. Bit 9 raises no pulse.
- R10: rstCmd always reads 0. Writes to it are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus access valid this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address in the window |
| reqWdata | input | 32 | Write data |
| rspRdata | output | 32 | Read data, combinational |
| rstPulse | output | 32 | Per-peripheral reset pulses, rstCmd bit map |
| sysRstReq | output | 1 | Sticky whole-system reset request |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- **Both group bits set at once.** A design that tests the peripheral group first would let the watchdog pulse and miss the GPIO banks.
- **A group bit together with an individual AES bit.** A design that merges rather than replaces would also pulse AES.
- **Misaligned writes and writes beyond the last register.** A design that decodes only the word index would corrupt clkCtl.
- **Two back-to-back rstCmd writes.** These check that each pulse lasts exactly one cycle and follows its own write.
- **A burst of unrelated traffic after a system reset command.** This shows whether sysRstReq is truly sticky and clears only on rstN.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 32;
  localparam int REG_COUNT = 18;
  localparam int IDX_W = $clog2(REG_COUNT);

  typedef enum logic [IDX_W-1:0] {
    REG_SYS, REG_RST, REG_CLK, REG_PWR, REG_PDIV, REG_GATEA,
    REG_MEM, REG_MCLR, REG_STAT, REG_RAUX, REG_GATEB, REG_EVT,
    REG_REV, REG_SIE, REG_EERR, REG_EDET, REG_EIE, REG_EADR
  } regSel_e;

  typedef struct packed {
    logic    wr;
    logic    rd;
    logic    rstWr;
    regSel_e sel;
  } strobe_t;

  localparam int SOFT_BIT    = 4;
  localparam int SYSRST_BIT  = 9;
  localparam int GROUP_BIT   = 31;
  localparam int CLK_RDY_BIT = 3;

  localparam logic [DATA_W-1:0] GROUP_SET   = 32'h3603_39E3;
  localparam logic [DATA_W-1:0] SOFT_SET    = 32'h3603_39ED;
  localparam logic [DATA_W-1:0] SINGLE_MASK = 32'h7603_39EF;
  localparam logic [DATA_W-1:0] SYS_KEEP    = 32'h0003_0000;
  localparam logic [DATA_W-1:0] SYS_FORCE   = 32'h0000_1002;

  function automatic logic [DATA_W-1:0] resetValue(int idx);
    case (idx)
      int'(REG_SYS):   return 32'h0002_1002;
      int'(REG_CLK):   return 32'h3E14_0008;
      int'(REG_PWR):   return 32'h0003_F000;
      int'(REG_GATEA): return 32'hFFFF_FFFF;
      int'(REG_MEM):   return 32'h0000_0005;
      int'(REG_GATEB): return 32'hFFFF_FFFF;
      int'(REG_REV):   return 32'h0000_00A1;
      default:         return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] writeFilter(regSel_e sel, logic [DATA_W-1:0] data);
    case (sel)
      REG_SYS: return (data & SYS_KEEP) | SYS_FORCE;
      REG_CLK: return data | (DATA_W'(1) << CLK_RDY_BIT);
      REG_RST: return '0;
      default: return data;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] expandRst(logic [DATA_W-1:0] cmd);
    if (cmd[SOFT_BIT]) return SOFT_SET;
    else if (cmd[GROUP_BIT]) return GROUP_SET;
    else return cmd & SINGLE_MASK;
  endfunction
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           strb
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              hit;

  always_comb begin
    wordIdx    = reqAddr[ADDR_W-1:2];
    hit        = (reqAddr[1:0] == 2'b00) && (wordIdx < WORD_W'(REG_COUNT));
    strb.sel   = regSel_e'(wordIdx[IDX_W-1:0]);
    strb.wr    = reqValid && reqWrite && hit;
    strb.rd    = reqValid && !reqWrite && hit;
    strb.rstWr = strb.wr && (strb.sel == REG_RST);
  end

  // R3: misaligned addresses never reach the datapath
  assert_misaligned_dropped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[1:0] != 2'b00) |-> !(strb.wr || strb.rd));
endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] rstPulse,
  output logic              sysRstReq
);
  logic [DATA_W-1:0] regs [REG_COUNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= resetValue(i);
    end else if (strb.wr) begin
      regs[strb.sel] <= writeFilter(strb.sel, wdata);
    end
  end

  always_comb rdata = strb.rd ? regs[strb.sel] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPulse  <= '0;
      sysRstReq <= 1'b0;
    end else begin
      rstPulse  <= strb.rstWr ? expandRst(wdata) : '0;
      sysRstReq <= sysRstReq | (strb.rstWr & wdata[SYSRST_BIT]);
    end
  end

  assert_sys_forced_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((regs[REG_SYS] & SYS_FORCE) == SYS_FORCE) && ((regs[REG_SYS] & ~(SYS_KEEP | SYS_FORCE)) == '0));
  assert_clk_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    regs[REG_CLK][CLK_RDY_BIT]);
  assert_pulse_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rstPulse != '0) |-> $past(strb.rstWr));
  assert_no_cmd_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstPulse & ~SINGLE_MASK) == '0);
  assert_sysreq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> sysRstReq);
  assert_cmd_not_stored_R10: assert property (@(posedge clk) disable iff (!rstN)
    regs[REG_RST] == '0);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       rspRdata,
  output logic [31:0]       rstPulse,
  output logic              sysRstReq
);
  strobe_t strb;

  sysctl_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .strb(strb)
  );

  sysctl_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(reqWdata),
    .rdata(rspRdata), .rstPulse(rstPulse), .sysRstReq(sysRstReq)
  );
endmodule

// File: tb/sysctl_regfile_test.sv
`timescale 1ns/1ps
module sysctl_regfile_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [9:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rspRdata, rstPulse;
  logic sysRstReq;

  always #2.5 clk = ~clk;

  sysctl_regfile uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .rstPulse(rstPulse), .sysRstReq(sysRstReq)
  );

  localparam logic [9:0] A_SYS = 10'h000, A_RST = 10'h004, A_CLK = 10'h008;
  localparam logic [31:0] P_SET = 32'h3603_39E3, S_SET = 32'h3603_39ED;

  logic [31:0] model [18];
  logic [31:0] pendPulse;
  string pendTag;
  bit sysNow;
  int checks = 0, errors = 0;
  bit done = 0;

  bit chkQ[$];
  logic [31:0] expRdQ[$], expPulseQ[$];
  bit expSysQ[$];
  string tagQ[$], pulseTagQ[$];

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic void resetModel();
    for (int i = 0; i < 18; i++) model[i] = 32'h0;
    model[0] = 32'h0002_1002; model[2] = 32'h3E14_0008; model[3] = 32'h0003_F000;
    model[5] = 32'hFFFF_FFFF; model[6] = 32'h5; model[10] = 32'hFFFF_FFFF;
    model[12] = 32'hA1;
    pendPulse = 0; pendTag = "R6"; sysNow = 0;
  endfunction

  function automatic bit decoded(logic [9:0] a);
    return (a[1:0] == 2'b00) && (a[9:2] < 8'd18);
  endfunction

  function automatic logic [31:0] expandModel(logic [31:0] d);
    if (d[4]) return S_SET;
    if (d[31]) return P_SET;
    return d & 32'h7603_39EF;
  endfunction

  task automatic cycle(bit v, bit w, logic [9:0] a, logic [31:0] d, bit chk, string tag);
    int idx;
    @(negedge clk);
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    chkQ.push_back(chk);
    expRdQ.push_back(decoded(a) ? model[a[9:2]] : 32'h0);
    expPulseQ.push_back(pendPulse);
    pulseTagQ.push_back(pendTag);
    expSysQ.push_back(sysNow);
    tagQ.push_back(tag);
    pendPulse = 0;
    if (v && w && decoded(a)) begin
      idx = int'(a[9:2]);
      case (idx)
        0: model[0] = (d & 32'h0003_0000) | 32'h1002;
        1: begin pendPulse = expandModel(d); pendTag = tag; if (d[9]) sysNow = 1; end
        2: model[2] = d | 32'h8;
        default: model[idx] = d;
      endcase
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, string tag); cycle(1, 1, a, d, 0, tag); endtask
  task automatic rd(logic [9:0] a, string tag); cycle(1, 0, a, 32'h0, 1, tag); endtask
  task automatic idle(string tag); cycle(0, 0, 10'h0, 32'h0, 0, tag); endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; reqValid = 0; reqWrite = 0;
    resetModel();
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  // monitor: pops one expectation per cycle and compares mid-phase
  initial forever begin
    @(negedge clk);
    #1;
    if (chkQ.size() > 0) begin
      bit c; logic [31:0] er, ep; bit es; string t, pt;
      c = chkQ.pop_front(); er = expRdQ.pop_front(); ep = expPulseQ.pop_front();
      es = expSysQ.pop_front(); t = tagQ.pop_front(); pt = pulseTagQ.pop_front();
      if (c) check(t, "rspRdata", rspRdata, er);
      check((ep != 0) ? pt : "R6", "rstPulse", rstPulse, ep);
      check("R9", "sysRstReq", {31'h0, sysRstReq}, {31'h0, es});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    resetModel();
    doReset();
    // R1 reset values, R10 command register reads zero
    for (int k = 0; k < 18; k++) rd(10'(k * 4), (k == 1) ? "R10" : "R1");
    // R2 plain registers
    for (int k = 3; k < 18; k++) if (k != 1) wr(10'(k * 4), 32'hA5A5_0000 + 32'(k), "R2");
    for (int k = 3; k < 18; k++) rd(10'(k * 4), "R2");
    wr(10'h014, 32'h5A5A_5A5A, "R2"); rd(10'h014, "R2");
    // R4 system control shaping
    wr(A_SYS, 32'hFFFF_FFFF, "R4"); rd(A_SYS, "R4");
    wr(A_SYS, 32'h0, "R4"); rd(A_SYS, "R4");
    wr(A_SYS, 32'h0001_0000, "R4"); rd(A_SYS, "R4");
    // R5 clock ready forced
    wr(A_CLK, 32'h0, "R5"); rd(A_CLK, "R5");
    wr(A_CLK, 32'hFFFF_FFF0, "R5"); rd(A_CLK, "R5");
    // R3 undecoded and misaligned
    rd(10'h048, "R3"); rd(10'h3FC, "R3");
    wr(10'h048, 32'h1234_5678, "R3"); rd(10'h048, "R3");
    wr(10'h009, 32'h0, "R3"); rd(A_CLK, "R3"); rd(10'h00A, "R3");
    wr(10'h005, 32'h4000_0001, "R3"); idle("R3"); idle("R3");
    // R6 individual pulses, one cycle, ignored bits
    wr(A_RST, 32'h4000_0001, "R6"); idle("R6"); idle("R6");
    wr(A_RST, 32'h0000_C400, "R6"); idle("R6");
    wr(A_RST, 32'h0000_000C, "R6"); wr(A_RST, 32'h2000_0800, "R6"); idle("R6"); idle("R6");
    // R7 peripheral group, individual AES dropped
    wr(A_RST, 32'h8000_0000, "R7"); idle("R7");
    wr(A_RST, 32'hC000_0000, "R7"); idle("R7");
    // R8 soft group and priority
    wr(A_RST, 32'h0000_0010, "R8"); idle("R8");
    wr(A_RST, 32'h8000_0010, "R8"); idle("R8");
    // R10 not stored
    rd(A_RST, "R10");
    // R9 sticky system request
    wr(A_RST, 32'h0000_0200, "R9"); idle("R9"); idle("R9");
    wr(10'h02C, 32'h1, "R9"); rd(A_RST, "R10"); wr(A_RST, 32'h0, "R9"); idle("R9");
    repeat (3) idle("R9");
    doReset();
    // R9 cleared by reset, R1 values restored
    idle("R9"); rd(A_SYS, "R1"); rd(A_CLK, "R1"); rd(10'h02C, "R1");
    idle("R1"); idle("R1");
    @(negedge clk); #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule